// File: doc/BRIEF.md
# Gated Edge Timestamp Capture

This block watches one asynchronous digital input and records when it changes. The input passes through a two-flop synchroniser. Once per clock (coarse) cycle, the synchronised sample is compared with the sample held from the cycle before. A mode input selects which transitions count: rising, falling, both, or none. A gate input decides whether a transition is accepted in a given cycle. Each accepted transition writes the value of a free-running 64-bit cycle counter, together with the new input level, into an event FIFO. A consumer drains the FIFO through a valid/ready port.

The comparison is made once per cycle, so the block produces at most one event per cycle. Transitions that arrive while the FIFO is full are dropped, and a sticky overflow flag is raised. The reader sees that flag beside the event stream and clears it with a dedicated pulse. A running count of accepted transitions is cleared each time the gate opens. When the gate closes, the count is latched into an output register that software can read.

Top module: `gtc_capture`

## Requirements
- R1: While reset is high and in the first cycle after it, evt_valid, ovf_flag and count_valid are 0 and edge_count is 0.
- R2: The timestamp counter holds 0 in the first cycle after reset and increases by 1 every cycle. An input change applied in a cycle where the counter holds T produces an event stamped T+2, provided the gate is high and the mode selects that transition.
- R3: edge_mode encoding: 2'b01 accepts rising transitions only, 2'b10 falling only, 2'b11 both, and 2'b00 none. An event's level field is the input level after the transition.
- R4: An input that toggles every cycle in mode 2'b11 produces one event per cycle, with consecutive stamps.
- R5: A transition is accepted only if gate_open is high in its detection cycle. The previous sample keeps tracking the input while the gate is closed, so a change made while the gate was closed produces no event when the gate reopens.
- R6: The FIFO is show-ahead. evt_valid is high whenever it holds an entry. An entry is removed on a cycle where evt_valid and evt_ready are both high. The entry is held stable while evt_ready is low. Events leave in arrival order, and an empty FIFO gives evt_valid low.
- R7: The FIFO holds FIFO_DEPTH entries (default 64). An accepted transition that finds it full is dropped, the stored entries are kept, and ovf_flag goes high in the next cycle.
- R8: ovf_flag stays high until ovf_clear is pulsed, including while the FIFO is drained. It is low in the cycle after the pulse.
- R9: The running count is cleared when gate_open rises. It counts every accepted transition, including those dropped on overflow. It is copied to edge_count at the first clock edge where gate_open is low after being high. count_valid is high from then until gate_open rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Coarse-cycle clock |
| rst | input | 1 | Synchronous active-high reset |
| sig_in | input | 1 | Asynchronous digital input being watched |
| gate_open | input | 1 | High while transitions are accepted |
| edge_mode | input | 2 | Transition selection (01 rise, 10 fall, 11 both, 00 none) |
| ovf_clear | input | 1 | One-cycle pulse that clears the overflow flag |
| evt_ready | input | 1 | Consumer accepts the presented event |
| evt_valid | output | 1 | An event is presented |
| evt_stamp | output | 64 | Timestamp of the presented event |
| evt_level | output | 1 | Input level after the presented transition |
| ovf_flag | output | 1 | Sticky flag: at least one event was lost |
| edge_count | output | CNT_W | Count of accepted transitions in the last closed window |
| count_valid | output | 1 | edge_count holds a finished window |

## Verification
A wrong previous-sample register shows up at the read port within three cycles of an input change. It appears as a missing event, a spurious event, or a stamp that is off by one or more. A corrupted FIFO pointer or occupancy count shows up at the next read as events out of order or repeated, or as evt_valid staying high past the expected drain. A mistake in the overflow or window-count logic appears only where those values are observed: when ovf_flag is checked after a full FIFO, and when edge_count is read one cycle after the gate closes.

// File: rtl/gtc_pkg.sv
package gtc_pkg;
    parameter int unsigned STAMP_W = 64;

    typedef enum logic [1:0] {
        GATE_OFF  = 2'b00,
        GATE_RISE = 2'b01,
        GATE_FALL = 2'b10,
        GATE_BOTH = 2'b11
    } gate_mode_e;

    typedef struct packed {
        logic [STAMP_W-1:0] stamp;
        logic               level;
    } evt_t;

    function automatic logic edge_match(logic prev, logic cur, gate_mode_e m);
        logic rise_ok;
        logic fall_ok;
        rise_ok = (m == GATE_RISE) || (m == GATE_BOTH);
        fall_ok = (m == GATE_FALL) || (m == GATE_BOTH);
        return (rise_ok && !prev && cur) || (fall_ok && prev && !cur);
    endfunction
endpackage

// File: rtl/gtc_sync.sv
module gtc_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gtc_edge_unit.sv
module gtc_edge_unit
    import gtc_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cur,
    input  logic             gate,
    input  logic [1:0]       mode,
    output logic             hit,
    output logic [CNT_W-1:0] count_q,
    output logic             count_ok
);
    logic             prev_q;
    logic             gate_q;
    logic [CNT_W-1:0] run_q;
    logic             gate_rise;
    logic             gate_fall;
    gate_mode_e       mode_e;

    assign mode_e    = gate_mode_e'(mode);
    assign hit       = gate && edge_match(prev_q, cur, mode_e);
    assign gate_rise = gate && !gate_q;
    assign gate_fall = !gate && gate_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= 1'b0;
            gate_q   <= 1'b0;
            run_q    <= '0;
            count_q  <= '0;
            count_ok <= 1'b0;
        end else begin
            prev_q <= cur;
            gate_q <= gate;
            if (gate_rise)
                run_q <= hit ? CNT_W'(1) : '0;
            else if (hit)
                run_q <= run_q + CNT_W'(1);
            if (gate_fall) begin
                count_q  <= run_q;
                count_ok <= 1'b1;
            end else if (gate_rise) begin
                count_ok <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/gtc_event_fifo.sv
module gtc_event_fifo #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned W     = 65
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         ready,
    output logic         valid,
    output logic [W-1:0] rdata,
    output logic         full
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW:0]   OCC_MAX = (AW+1)'(DEPTH);
    localparam logic [AW-1:0] PTR_END = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;
    logic [AW:0]   occ;
    logic          do_push;
    logic          do_pop;

    assign full    = (occ == OCC_MAX);
    assign valid   = (occ != '0);
    assign rdata   = mem[rptr];
    assign do_push = push && !full;
    assign do_pop  = valid && ready;

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
            occ  <= '0;
        end else begin
            if (do_push) wptr <= (wptr == PTR_END) ? '0 : wptr + AW'(1);
            if (do_pop)  rptr <= (rptr == PTR_END) ? '0 : rptr + AW'(1);
            case ({do_push, do_pop})
                2'b10:   occ <= occ + (AW+1)'(1);
                2'b01:   occ <= occ - (AW+1)'(1);
                default: occ <= occ;
            endcase
        end
    end
endmodule

// File: rtl/gtc_capture.sv
module gtc_capture
    import gtc_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH  = 64,
    parameter int unsigned CNT_W       = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sig_in,
    input  logic               gate_open,
    input  logic [1:0]         edge_mode,
    input  logic               ovf_clear,
    input  logic               evt_ready,
    output logic               evt_valid,
    output logic [STAMP_W-1:0] evt_stamp,
    output logic               evt_level,
    output logic               ovf_flag,
    output logic [CNT_W-1:0]   edge_count,
    output logic               count_valid
);
    localparam int unsigned EVT_W = $bits(evt_t);

    logic               sig_s;
    logic               hit;
    logic               fifo_full;
    logic [STAMP_W-1:0] ts_q;
    logic               ovf_q;
    evt_t               wr_evt;
    evt_t               rd_evt;

    always_ff @(posedge clk) begin
        if (rst) ts_q <= '0;
        else     ts_q <= ts_q + STAMP_W'(1);
    end

    gtc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (sig_in),
        .q   (sig_s)
    );

    gtc_edge_unit #(.CNT_W(CNT_W)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .cur      (sig_s),
        .gate     (gate_open),
        .mode     (edge_mode),
        .hit      (hit),
        .count_q  (edge_count),
        .count_ok (count_valid)
    );

    assign wr_evt.stamp = ts_q;
    assign wr_evt.level = sig_s;

    gtc_event_fifo #(.DEPTH(FIFO_DEPTH), .W(EVT_W)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (hit),
        .wdata (wr_evt),
        .ready (evt_ready),
        .valid (evt_valid),
        .rdata (rd_evt),
        .full  (fifo_full)
    );

    always_ff @(posedge clk) begin
        if (rst)                   ovf_q <= 1'b0;
        else if (hit && fifo_full) ovf_q <= 1'b1;
        else if (ovf_clear)        ovf_q <= 1'b0;
    end

    assign ovf_flag  = ovf_q;
    assign evt_stamp = rd_evt.stamp;
    assign evt_level = rd_evt.level;
endmodule

// File: rtl/gtc_capture_chk.sv
module gtc_capture_chk #(
    parameter int unsigned STAMP_W = 64,
    parameter int unsigned CNT_W   = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               gate_open,
    input logic               ovf_clear,
    input logic               evt_ready,
    input logic               evt_valid,
    input logic [STAMP_W-1:0] evt_stamp,
    input logic               evt_level,
    input logic               ovf_flag,
    input logic [CNT_W-1:0]   edge_count,
    input logic               count_valid
);
    AST_HOLD_UNTIL_READ: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && !evt_ready) |=> (evt_valid && $stable(evt_stamp) && $stable(evt_level))); // R6

    AST_STAMP_ORDER: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && evt_ready) |=> (!evt_valid || (evt_stamp > $past(evt_stamp)))); // R6

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !ovf_clear) |=> ovf_flag); // R8

    AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (count_valid && !gate_open) |=> $stable(edge_count)); // R9

    AST_COUNT_DROPS_ON_OPEN: assert property (@(posedge clk) disable iff (rst)
        (gate_open && count_valid && !$past(gate_open)) |=> !count_valid); // R9
endmodule

bind gtc_capture gtc_capture_chk #(.STAMP_W(gtc_pkg::STAMP_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .gate_open   (gate_open),
    .ovf_clear   (ovf_clear),
    .evt_ready   (evt_ready),
    .evt_valid   (evt_valid),
    .evt_stamp   (evt_stamp),
    .evt_level   (evt_level),
    .ovf_flag    (ovf_flag),
    .edge_count  (edge_count),
    .count_valid (count_valid)
);

// File: tb/tb_gtc_capture.sv
`timescale 1ns/1ps
module tb_gtc_capture;
    import gtc_pkg::*;

    localparam int DEPTH = 64;
    localparam int CW    = 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            sig_in = 1'b0;
    logic            gate_open = 1'b0;
    logic [1:0]      edge_mode = 2'b11;
    logic            ovf_clear = 1'b0;
    logic            evt_ready = 1'b1;
    logic            evt_valid;
    logic [63:0]     evt_stamp;
    logic            evt_level;
    logic            ovf_flag;
    logic [CW-1:0]   edge_count;
    logic            count_valid;

    gtc_capture #(.FIFO_DEPTH(DEPTH), .CNT_W(CW)) dut (
        .clk(clk), .rst(rst), .sig_in(sig_in), .gate_open(gate_open),
        .edge_mode(edge_mode), .ovf_clear(ovf_clear), .evt_ready(evt_ready),
        .evt_valid(evt_valid), .evt_stamp(evt_stamp), .evt_level(evt_level),
        .ovf_flag(ovf_flag), .edge_count(edge_count), .count_valid(count_valid)
    );

    always #2.5 clk = ~clk;

    int          checks = 0;
    int          errors = 0;
    int          occ = 0;
    int          exp_cnt = 0;
    logic        last_in = 1'b0;
    logic [63:0] tcount = 0;
    evt_t        exp_q[$];

    always @(posedge clk) begin
        if (rst) tcount <= 0;
        else     tcount <= tcount + 1;
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Driver: apply input level, predict the event per R2/R3/R5/R7/R9
    task automatic apply(input logic v);
        bit take;
        @(negedge clk);
        sig_in = v;
        if (v != last_in && gate_open) begin
            take = (edge_mode == 2'b11) ||
                   (edge_mode == 2'b01 && v) ||
                   (edge_mode == 2'b10 && !v);
            if (take) begin
                exp_cnt++;
                if (occ < DEPTH) begin
                    exp_q.push_back('{stamp: tcount + 2, level: v});
                    occ++;
                end
            end
        end
        last_in = v;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_gate(input logic g);
        @(negedge clk);
        gate_open = g;
        if (g) exp_cnt = 0;
    endtask

    // Monitor: scoreboard compare on each read (R2, R3, R6)
    always @(negedge clk) begin
        if (!rst && evt_valid && evt_ready) begin
            if (exp_q.size() == 0) begin
                check(0, "R6 unexpected event", evt_stamp, 0);
            end else begin
                evt_t e;
                e = exp_q.pop_front();
                check(evt_stamp == e.stamp, "R2 stamp", evt_stamp, e.stamp);
                check(evt_level == e.level, "R3 level", {63'd0, evt_level}, {63'd0, e.level});
                occ--;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        summary();
        $finish;
    end

    initial begin
        logic [63:0] held;
        repeat (4) @(negedge clk);
        check(evt_valid == 0 && ovf_flag == 0 && count_valid == 0 && edge_count == 0,
              "R1 reset outputs", {evt_valid, ovf_flag, count_valid}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(evt_valid == 0 && ovf_flag == 0 && count_valid == 0 && edge_count == 0,
              "R1 after reset", {evt_valid, ovf_flag, count_valid}, 0);

        // R2/R3: both edges
        set_gate(1);
        edge_mode = 2'b11;
        apply(1); idle(3); apply(0); idle(3);
        // R3: rising only
        edge_mode = 2'b01;
        apply(1); idle(3); apply(0); idle(3); apply(1); idle(3); apply(0); idle(3);
        // R3: falling only
        edge_mode = 2'b10;
        apply(1); idle(3); apply(0); idle(3);
        // R3: none
        edge_mode = 2'b00;
        apply(1); idle(3); apply(0); idle(4);
        check(evt_valid == 0 && exp_q.size() == 0, "R3 mode off gives no event", {63'd0, evt_valid}, 0);

        // R4: toggle every cycle
        edge_mode = 2'b11;
        apply(1); apply(0); apply(1); apply(0); apply(1); apply(0);
        idle(6);
        check(exp_q.size() == 0, "R4 back-to-back drained", exp_q.size(), 0);

        // R9: window count latched after close
        set_gate(0);
        idle(2);
        check(count_valid == 1, "R9 count_valid after close", {63'd0, count_valid}, 1);
        check(edge_count == exp_cnt, "R9 edge_count", edge_count, exp_cnt);

        // R5: change while closed, no event on reopening
        apply(1); idle(4);
        set_gate(1);
        idle(4);
        check(evt_valid == 0, "R5 no event after reopen", {63'd0, evt_valid}, 0);
        check(count_valid == 0, "R9 count_valid low while open", {63'd0, count_valid}, 0);
        apply(0); idle(4);
        check(exp_q.size() == 0, "R5 falling seen after reopen", exp_q.size(), 0);
        set_gate(0);
        idle(2);
        check(edge_count == 1, "R9 edge_count one", edge_count, 1);

        // R7: overflow
        evt_ready = 1'b0;
        set_gate(1);
        for (int i = 0; i < 70; i++) begin
            apply(~last_in); idle(1);
        end
        idle(4);
        check(ovf_flag == 1, "R7 overflow set", {63'd0, ovf_flag}, 1);
        check(evt_valid == 1, "R7 entries kept", {63'd0, evt_valid}, 1);
        held = evt_stamp;
        idle(3);
        check(evt_stamp == held, "R6 hold while not ready", evt_stamp, held);
        set_gate(0);
        idle(2);
        check(edge_count == 70, "R9 count includes dropped", edge_count, 70);
        @(negedge clk);
        evt_ready = 1'b1;
        idle(DEPTH + 8);
        check(evt_valid == 0, "R6 empty gives valid low", {63'd0, evt_valid}, 0);
        check(exp_q.size() == 0, "R7 all stored entries read", exp_q.size(), 0);
        check(ovf_flag == 1, "R8 sticky after drain", {63'd0, ovf_flag}, 1);
        @(negedge clk); ovf_clear = 1'b1;
        @(negedge clk); ovf_clear = 1'b0;
        check(ovf_flag == 0, "R8 cleared", {63'd0, ovf_flag}, 0);
        idle(2);
        summary();
        $finish;
    end
endmodule